// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the 13-bit fetch address of a small 8-bit controller core and decides, every clock cycle, where the next instruction comes from. It can step to the next address, take a computed low byte from the ALU, jump to an absolute target, call a subroutine, or return from one. The low eight address bits can be read back as a data byte. The five upper bits are never written directly. They are taken from an 8-bit page latch that the core writes through its own port. Which latch bits are used depends on the kind of load.

Subroutine return addresses are kept on an eight-entry circular hardware stack. The stack has no overflow or underflow flag. Its pointer wraps in both directions, so deep nesting silently overwrites the oldest entry. Decode, the ALU and program memory stay outside the block. The core presents an operation code, an 11-bit opcode immediate and the ALU result each cycle.

Top module: `paged_pc_unit`

## Requirements
- R1: While rst_n is low, fetch_addr is 0x0000, the page latch is 0x00 and the stack pointer is 0. The latch value is observable through the first low-byte load after reset.
- R2: pcl_rdata always equals fetch_addr[7:0].
- R3: For op_sel code 1 (low-byte load), the next fetch_addr is {latch[4:0], alu_res[7:0]}. Latch bits 7:5 have no effect.
- R4: For op_sel code 2 (jump), the next fetch_addr is {latch[4:3], imm[10:0]}. Latch bits 2:0 and 7:5 have no effect.
- R5: For op_sel code 3 (call), fetch_addr+1 (modulo 2^13) is pushed onto the stack, and the next fetch_addr is {latch[4:3], imm[10:0]}.
- R6: For op_sel code 4 (return), the next fetch_addr is the most recently pushed stack entry, and that entry is popped.
- R7: For op_sel code 0, and for the unused codes 5, 6 and 7, fetch_addr increments by one and wraps from 0x1FFF to 0x0000.
- R8: The latch takes latch_wdata on a cycle with latch_we high and is otherwise unchanged, whatever PC operation runs. A load in the same cycle as a latch write uses the old latch value.
- R9: The stack holds eight entries and its pointer wraps. A ninth push overwrites the oldest entry, and later pops keep cycling through the eight entries without any indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| op_sel | input | 3 | Update select: 0 step, 1 low-byte load, 2 jump, 3 call, 4 return |
| imm | input | 11 | Opcode immediate used by jump and call |
| alu_res | input | 8 | ALU result used by the low-byte load |
| latch_we | input | 1 | Page latch write enable |
| latch_wdata | input | 8 | Page latch write data |
| pcl_rdata | output | 8 | Read port for the low address byte |
| fetch_addr | output | 13 | Current instruction fetch address |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 8-bit low byte, an 11-bit immediate and a stack depth of eight. With these values the 0x1FFF wrap, the choice between latch bits [4:3] and [4:0], and the ninth-push overwrite all fall within a few hundred cycles. A nine-deep call chain followed by ten returns drives the pointer around the ring in both directions. Same-cycle latch writes combined with loads show which latch value each load sees.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    PC_OP_STEP  = 3'd0,
    PC_OP_LOWWR = 3'd1,
    PC_OP_JUMP  = 3'd2,
    PC_OP_CALL  = 3'd3,
    PC_OP_RET   = 3'd4
  } pc_op_e;
endpackage

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_data,
  output logic [LAT_W-1:0] lat_q
);
  logic [LAT_W-1:0] lat_d;

  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [W-1:0]     ent_q [DEPTH];

  always_comb begin
    ptr_d = ptr_q;
    if (push)     ptr_d = ptr_q + PTR_ONE;
    else if (pop) ptr_d = ptr_q - PTR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = push && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (ent_en) ent_q[g] <= push_data;
    end
  end

  assign top_data = ent_q[ptr_q - PTR_ONE];
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pcs_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int IMM_W = 11
) (
  input  logic [2:0]          op,
  input  logic [PC_W-1:0]     pc_q,
  input  logic [IMM_W-1:0]    imm,
  input  logic [LOW_W-1:0]    alu,
  input  logic [PC_W-LOW_W-1:0] page,
  input  logic [PC_W-1:0]     stk_top,
  output logic [PC_W-1:0]     pc_d,
  output logic                push,
  output logic                pop,
  output logic [PC_W-1:0]     ret_addr
);
  localparam int HI_W = PC_W - LOW_W;
  localparam int JHI  = PC_W - IMM_W;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] jmp_tgt;

  assign pc_inc   = pc_q + {{(PC_W-1){1'b0}}, 1'b1};
  assign jmp_tgt  = {page[HI_W-1 -: JHI], imm};
  assign ret_addr = pc_inc;

  always_comb begin
    pc_d = pc_inc;
    push = 1'b0;
    pop  = 1'b0;
    case (op)
      PC_OP_LOWWR: pc_d = {page, alu};
      PC_OP_JUMP:  pc_d = jmp_tgt;
      PC_OP_CALL: begin
        pc_d = jmp_tgt;
        push = 1'b1;
      end
      PC_OP_RET: begin
        pc_d = stk_top;
        pop  = 1'b1;
      end
      default: pc_d = pc_inc;
    endcase
  end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit #(
  parameter int PC_W      = 13,
  parameter int LOW_W     = 8,
  parameter int IMM_W     = 11,
  parameter int LAT_W     = 8,
  parameter int STK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [LOW_W-1:0] alu_res,
  input  logic             latch_we,
  input  logic [LAT_W-1:0] latch_wdata,
  output logic [LOW_W-1:0] pcl_rdata,
  output logic [PC_W-1:0]  fetch_addr
);
  localparam int HI_W = PC_W - LOW_W;

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LAT_W-1:0] latch_q;
  logic [PC_W-1:0]  stk_top, ret_addr;
  logic             push, pop;
  logic             unused_lat_hi;

  assign unused_lat_hi = ^latch_q[LAT_W-1:HI_W];

  pc_page_latch #(.LAT_W(LAT_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_we),
    .wr_data (latch_wdata),
    .lat_q   (latch_q)
  );

  pc_next_sel #(.PC_W(PC_W), .LOW_W(LOW_W), .IMM_W(IMM_W)) u_sel (
    .op       (op_sel),
    .pc_q     (pc_q),
    .imm      (imm),
    .alu      (alu_res),
    .page     (latch_q[HI_W-1:0]),
    .stk_top  (stk_top),
    .pc_d     (pc_d),
    .push     (push),
    .pop      (pop),
    .ret_addr (ret_addr)
  );

  pc_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (ret_addr),
    .top_data  (stk_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign pcl_rdata  = pc_q[LOW_W-1:0];
endmodule

// File: rtl/paged_pc_unit_chk.sv
module paged_pc_unit_chk
  import pcs_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int IMM_W = 11,
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_sel,
  input logic [IMM_W-1:0] imm,
  input logic [LOW_W-1:0] alu_res,
  input logic             latch_we,
  input logic [LAT_W-1:0] latch_wdata,
  input logic [PC_W-1:0]  fetch_addr,
  input logic [LAT_W-1:0] latch_q
);
  localparam int HI_W = PC_W - LOW_W;
  localparam int JHI  = PC_W - IMM_W;

  // R3: low-byte load combines latch page bits with ALU result
  a_r3_lowwr_load: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == PC_OP_LOWWR |=>
      fetch_addr == {$past(latch_q[HI_W-1:0]), $past(alu_res)});

  // R4: jump uses the top latch page bits and the immediate
  a_r4_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == PC_OP_JUMP |=>
      fetch_addr == {$past(latch_q[HI_W-1 -: JHI]), $past(imm)});

  // R5, R6: a call immediately followed by a return lands after the call
  a_r6_call_ret_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == PC_OP_CALL) ##1 (op_sel == PC_OP_RET) |=>
      fetch_addr == $past(fetch_addr, 2) + {{(PC_W-1){1'b0}}, 1'b1});

  // R7: stepping increments with wrap
  a_r7_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == PC_OP_STEP || op_sel > PC_OP_RET) |=>
      fetch_addr == $past(fetch_addr) + {{(PC_W-1){1'b0}}, 1'b1});

  // R8: the latch changes only on its own write port
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(latch_q));

  a_r8_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    latch_we |=> latch_q == $past(latch_wdata));
endmodule

bind paged_pc_unit paged_pc_unit_chk #(
  .PC_W(PC_W), .LOW_W(LOW_W), .IMM_W(IMM_W), .LAT_W(LAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_sel      (op_sel),
  .imm         (imm),
  .alu_res     (alu_res),
  .latch_we    (latch_we),
  .latch_wdata (latch_wdata),
  .fetch_addr  (fetch_addr),
  .latch_q     (latch_q)
);

// File: tb/paged_pc_unit_bench.sv
`timescale 1ns/1ps
module paged_pc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [10:0] imm = '0;
  logic [7:0]  alu_res = '0;
  logic        latch_we = 1'b0;
  logic [7:0]  latch_wdata = '0;
  logic [7:0]  pcl_rdata;
  logic [12:0] fetch_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [12:0] exp_q [$];
  string       tag_q [$];

  logic [12:0] m_pc = '0;
  logic [7:0]  m_lat = '0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = '0;

  always #2 clk = ~clk;

  paged_pc_unit u_paged_pc_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .imm(imm), .alu_res(alu_res),
    .latch_we(latch_we), .latch_wdata(latch_wdata),
    .pcl_rdata(pcl_rdata), .fetch_addr(fetch_addr)
  );

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of stimulus and queue the predicted address
  task automatic drive(input logic [2:0] op, input logic [10:0] im,
                       input logic [7:0] alu, input bit lwe,
                       input logic [7:0] ld, input string tag);
    logic [12:0] nxt;
    @(negedge clk);
    op_sel = op; imm = im; alu_res = alu; latch_we = lwe; latch_wdata = ld;
    case (op)
      3'd1: nxt = {m_lat[4:0], alu};
      3'd2: nxt = {m_lat[4:3], im};
      3'd3: begin
        m_stk[m_sp] = m_pc + 13'd1;
        m_sp = m_sp + 3'd1;
        nxt = {m_lat[4:3], im};
      end
      3'd4: begin
        m_sp = m_sp - 3'd1;
        nxt = m_stk[m_sp];
      end
      default: nxt = m_pc + 13'd1;
    endcase
    if (lwe) m_lat = ld;
    m_pc = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, fetch_addr, e);
        chk("R2", {5'd0, pcl_rdata}, {5'd0, fetch_addr[7:0]});
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #9;
    chk("R1", fetch_addr, 13'h0000);
    chk("R2", {5'd0, pcl_rdata}, 13'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: latch reset to zero, seen via low-byte load (R3)
    drive(3'd1, 11'h000, 8'h34, 1'b0, 8'h00, "R1");
    for (int i = 0; i < 3; i++) drive(3'd0, 11'h5A5, 8'hEE, 1'b0, 8'h00, "R7");
    // R8: latch write during a step, then used by a load
    drive(3'd0, 11'h000, 8'h00, 1'b1, 8'h15, "R8");
    drive(3'd1, 11'h000, 8'h80, 1'b0, 8'h00, "R3");
    // R8: jump in the same cycle as a latch write sees the old latch
    drive(3'd2, 11'h123, 8'h00, 1'b1, 8'hFF, "R8");
    drive(3'd2, 11'h7FF, 8'h00, 1'b0, 8'h00, "R4");
    drive(3'd0, 11'h000, 8'h00, 1'b0, 8'h00, "R7");
    // R3: latch bits 7:5 ignored
    drive(3'd1, 11'h000, 8'hFF, 1'b0, 8'h00, "R3");
    drive(3'd0, 11'h000, 8'h00, 1'b0, 8'h00, "R7");
    // R7: unused codes step
    drive(3'd5, 11'h3FF, 8'h11, 1'b0, 8'h00, "R7");
    drive(3'd6, 11'h3FF, 8'h22, 1'b0, 8'h00, "R7");
    drive(3'd7, 11'h3FF, 8'h33, 1'b0, 8'h00, "R7");
    // R4: latch bits 2:0 ignored by jump
    drive(3'd0, 11'h000, 8'h00, 1'b1, 8'h0F, "R7");
    drive(3'd2, 11'h456, 8'h00, 1'b0, 8'h00, "R4");
    // R5/R6: nested call and return
    drive(3'd0, 11'h000, 8'h00, 1'b1, 8'h08, "R7");
    drive(3'd3, 11'h055, 8'h00, 1'b0, 8'h00, "R5");
    drive(3'd0, 11'h000, 8'h00, 1'b0, 8'h00, "R7");
    drive(3'd3, 11'h200, 8'h00, 1'b0, 8'h00, "R5");
    drive(3'd0, 11'h000, 8'h00, 1'b0, 8'h00, "R7");
    drive(3'd4, 11'h000, 8'h00, 1'b0, 8'h00, "R6");
    drive(3'd4, 11'h000, 8'h00, 1'b0, 8'h00, "R6");
    // R5: call from the top address wraps the return address
    drive(3'd0, 11'h000, 8'h00, 1'b1, 8'h1F, "R7");
    drive(3'd1, 11'h000, 8'hFF, 1'b0, 8'h00, "R3");
    drive(3'd3, 11'h001, 8'h00, 1'b0, 8'h00, "R5");
    drive(3'd4, 11'h000, 8'h00, 1'b0, 8'h00, "R6");
    // R9: nine pushes, ten pops
    for (int i = 0; i < 9; i++)
      drive(3'd3, 11'(i * 37 + 3), 8'h00, 1'b0, 8'h00, "R9");
    for (int i = 0; i < 10; i++)
      drive(3'd4, 11'h000, 8'h00, 1'b0, 8'h00, "R9");
    // R8: no PC operation touched the latch
    drive(3'd1, 11'h000, 8'h5C, 1'b0, 8'h00, "R8");
    drive(3'd0, 11'h000, 8'h00, 1'b0, 8'h00, "R7");
    @(negedge clk);
    op_sel = 3'd0;
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule